// File: doc/BRIEF.md
# Banked Memory-Mapped Interrupt Controller

This block gathers interrupt requests for one processor from two groups of sources. The first group is 64 shared lines, split into two banks of 32. The second is a small group of lines private to the processor. Every line first passes through a two-flop synchronizer. Its pending bit is the synchronized level gated by a per-line enable bit. A single request output is raised whenever any enabled line is active.

Software drives the block over a plain 32-bit register bus made of byte address, write strobe, write data and a combinational read-data return. Each bank has its own set register and its own clear register for the enable mask. Writing a 1 to a bit of a set register enables that line, and writing a 1 to a bit of a clear register disables it. Bits written as 0 change nothing.

The controller cannot clear a pending interrupt: a source keeps its pending bit until it drops its own line. A summary register gives the private pending bits and one OR bit per shared bank. Above those it mirrors a parameterized list of shared lines. Those mirrored lines belong to the shared banks, so the private-bank enable registers cannot reach them.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset all enable bits are 0, so every enable read (offsets 0x10 to 0x24) returns 0. Every pending read returns 0 and irq_out is low, even while sources are high.
- R2: A write to 0x10 (shared lines 0..31, line n at bit n), 0x14 (shared lines 32..63, line 32+n at bit n) or 0x18 (private lines, line p at bit p) sets the enable bits written as 1. Bits written as 0 keep their value.
- R3: A write to 0x1C, 0x20 or 0x24 clears the enable bits written as 1 in shared bank 1, shared bank 2 or the private bank respectively. Bits written as 0 keep their value.
- R4: Offset 0x04 reads the synchronized levels of shared lines 0..31 ANDed with their enables. Offset 0x08 does the same for lines 32..63. Bits 7:0 of offset 0x00 do the same for the 8 private lines.
- R5: Writes to the pending offsets 0x00, 0x04 and 0x08 have no effect. A pending bit drops only when its source line goes low.
- R6: Bit 8 of offset 0x00 is the OR of the enabled pending bits of shared bank 1. Bit 9 is the same OR for shared bank 2.
- R7: Bit 10+k of offset 0x00 is the enabled pending state of the k-th entry of the mirror list, which defaults to shared lines 3, 9, 55, 57 and 62 for k = 0 to 4. Writes to 0x18 and 0x24 never change any shared enable bit.
- R8: A read of either the set offset or the clear offset of a bank returns that bank's current enable mask. The private mask is zero-extended.
- R9: A read of any address that is not one of the word-aligned offsets 0x00, 0x04, 0x08 or 0x10 to 0x24 returns 0. This covers the reserved 0x0C, offsets from 0x28 up, and addresses with bits 1:0 non-zero. Writes to such addresses change nothing.
- R10: irq_out is the OR of every enabled pending bit, shared and private.
- R11: A source level present before clock edge n is reflected in pending bits and irq_out after edge n+1 and not after edge n.
- R12: When a bit gets a set write and then a clear write on consecutive cycles, the later write wins, and the same holds for a clear write followed by a set write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shared_irq_in | input | 64 | Shared interrupt source levels, line n at bit n |
| priv_irq_in | input | 8 | Private interrupt source levels |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench writes patterns containing both 1 and 0 bits to each set and clear register. A design that treated these as plain stores would wipe the untouched enable bits. It writes all-ones to the pending offsets, expecting no change; a design that cleared pending on write would lose the interrupt. It also writes wide values to the private registers while mirrored lines are active, which catches a design that aliases the summary bits onto shared enables. Further tests cover reserved and misaligned addresses, the exact two-edge synchronizer latency, and set and clear writes on back-to-back beats, where a design with a wrong priority or one missing flop would keep the earlier write or answer one cycle off.

// File: rtl/bank_irq_pkg.sv
// Package: shared constants of the banked interrupt controller.
// Holds the bus width and the word index of every defined register.
package bank_irq_pkg;
    localparam int DATA_W       = 32;  // bus and shared-bank width
    localparam int WI_SUMMARY   = 0;   // 0x00 summary / private pending
    localparam int WI_SH1_PEND  = 1;   // 0x04 shared lines 0..31 pending
    localparam int WI_SH2_PEND  = 2;   // 0x08 shared lines 32..63 pending
    localparam int WI_RESERVED  = 3;   // 0x0C reserved, reads zero
    localparam int WI_SH1_SET   = 4;   // 0x10
    localparam int WI_SH2_SET   = 5;   // 0x14
    localparam int WI_PRIV_SET  = 6;   // 0x18
    localparam int WI_SH1_CLR   = 7;   // 0x1C
    localparam int WI_SH2_CLR   = 8;   // 0x20
    localparam int WI_PRIV_CLR  = 9;   // 0x24
endpackage

// File: rtl/irq_sync.sv
// Two-flop level synchronizer for a vector of asynchronous interrupt lines.
// Assumes each line is a level that stays stable for several clocks.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // R11
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/irq_enable_bank.sv
// Enable mask of one bank, changed only by write-1-to-set and
// write-1-to-clear strobes. Assumes at most one strobe per cycle.
module irq_enable_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] en
);
    // Apply set or clear only to the bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (set_we)
            en <= en | wbits;
        else if (clr_we)
            en <= en & ~wbits;
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en & $past(wbits)) == $past(wbits)));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en & $past(wbits)) == '0));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/irq_summary.sv
// Builds the summary register: private pending bits, one OR bit per shared
// bank, then a parameterized list of mirrored shared lines.
// Assumes PRIV_W + 2 + MIRROR_NUM fits in the bus width.
module irq_summary
    import bank_irq_pkg::*;
#(
    parameter int          PRIV_W      = 8,
    parameter int          SH_W        = 64,
    parameter int          MIRROR_NUM  = 5,
    parameter logic [8*MIRROR_NUM-1:0] MIRROR_LIST = '0
) (
    input  logic [PRIV_W-1:0] priv_pend,
    input  logic [SH_W-1:0]   sh_pend,
    output logic [DATA_W-1:0] summary
);
    localparam int BANK_W = SH_W / 2;
    localparam int MIR_BASE = PRIV_W + 2;

    logic [MIRROR_NUM-1:0] mirror;

    // One tap per mirror list entry.
    for (genvar k = 0; k < MIRROR_NUM; k++) begin : g_mirror
        localparam int LINE = int'(MIRROR_LIST[8*k +: 8]);
        assign mirror[k] = sh_pend[LINE];
    end

    // Place private bits, bank ORs and mirror taps into one word.
    always_comb begin
        summary = '0;
        summary[PRIV_W-1:0] = priv_pend;
        summary[PRIV_W]     = |sh_pend[BANK_W-1:0];
        summary[PRIV_W+1]   = |sh_pend[SH_W-1:BANK_W];
        summary[MIR_BASE +: MIRROR_NUM] = mirror;
    end
endmodule

// File: rtl/bank_irq_ctrl.sv
// Banked interrupt controller top: synchronizes the sources, holds the
// enable masks, decodes the register bus and raises one request line.
// Assumes one register access per cycle and byte addresses on the bus.
module bank_irq_ctrl
    import bank_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PRIV_W     = 8,
    parameter int MIRROR_NUM = 5,
    parameter logic [8*MIRROR_NUM-1:0] MIRROR_LIST =
        {8'd62, 8'd57, 8'd55, 8'd9, 8'd3}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [2*DATA_W-1:0]  shared_irq_in,
    input  logic [PRIV_W-1:0]    priv_irq_in,
    output logic                 irq_out
);
    localparam int BANK_W = DATA_W;
    localparam int SH_W   = 2 * BANK_W;
    localparam int WIDX_W = ADDR_W - 2;
    localparam int NBANK  = 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic [SH_W-1:0]   sh_sync;
    logic [PRIV_W-1:0] priv_sync;
    logic [SH_W-1:0]   sh_en;
    logic [PRIV_W-1:0] priv_en;
    logic [SH_W-1:0]   sh_pend;
    logic [PRIV_W-1:0] priv_pend;
    logic [DATA_W-1:0] summary;
    logic [NBANK-1:0]  sh_set_we;
    logic [NBANK-1:0]  sh_clr_we;
    logic              priv_set_we;
    logic              priv_clr_we;
    logic              addr_defined;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    irq_sync #(.W(SH_W)) u_sh_sync (
        .clk(clk), .rst_n(rst_n), .d(shared_irq_in), .q(sh_sync)
    );

    irq_sync #(.W(PRIV_W)) u_priv_sync (
        .clk(clk), .rst_n(rst_n), .d(priv_irq_in), .q(priv_sync)
    );

    // Decode the strobes of both shared banks.
    always_comb begin
        sh_set_we[0] = bus_we && aligned && (widx == WIDX_W'(WI_SH1_SET));
        sh_set_we[1] = bus_we && aligned && (widx == WIDX_W'(WI_SH2_SET));
        sh_clr_we[0] = bus_we && aligned && (widx == WIDX_W'(WI_SH1_CLR));
        sh_clr_we[1] = bus_we && aligned && (widx == WIDX_W'(WI_SH2_CLR));
    end

    assign priv_set_we = bus_we && aligned && (widx == WIDX_W'(WI_PRIV_SET));
    assign priv_clr_we = bus_we && aligned && (widx == WIDX_W'(WI_PRIV_CLR));

    for (genvar b = 0; b < NBANK; b++) begin : g_sh_bank
        irq_enable_bank #(.W(BANK_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_we(sh_set_we[b]), .clr_we(sh_clr_we[b]),
            .wbits(bus_wdata),
            .en(sh_en[b*BANK_W +: BANK_W])
        );
    end

    irq_enable_bank #(.W(PRIV_W)) u_priv_bank (
        .clk(clk), .rst_n(rst_n),
        .set_we(priv_set_we), .clr_we(priv_clr_we),
        .wbits(bus_wdata[PRIV_W-1:0]),
        .en(priv_en)
    );

    assign sh_pend   = sh_sync & sh_en;
    assign priv_pend = priv_sync & priv_en;

    irq_summary #(
        .PRIV_W(PRIV_W), .SH_W(SH_W),
        .MIRROR_NUM(MIRROR_NUM), .MIRROR_LIST(MIRROR_LIST)
    ) u_summary (
        .priv_pend(priv_pend), .sh_pend(sh_pend), .summary(summary)
    );

    assign irq_out = (|sh_pend) | (|priv_pend);

    // Select read data by word index; undefined addresses return zero.
    always_comb begin
        bus_rdata    = '0;
        addr_defined = aligned;
        case (widx)
            WIDX_W'(WI_SUMMARY):  bus_rdata = summary;
            WIDX_W'(WI_SH1_PEND): bus_rdata = sh_pend[BANK_W-1:0];
            WIDX_W'(WI_SH2_PEND): bus_rdata = sh_pend[SH_W-1:BANK_W];
            WIDX_W'(WI_SH1_SET),
            WIDX_W'(WI_SH1_CLR):  bus_rdata = sh_en[BANK_W-1:0];
            WIDX_W'(WI_SH2_SET),
            WIDX_W'(WI_SH2_CLR):  bus_rdata = sh_en[SH_W-1:BANK_W];
            WIDX_W'(WI_PRIV_SET),
            WIDX_W'(WI_PRIV_CLR): bus_rdata = {{(DATA_W-PRIV_W){1'b0}}, priv_en};
            default:              addr_defined = 1'b0;
        endcase
        if (!aligned)
            bus_rdata = '0;
    end

    // R9
    undefined_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_defined || widx == WIDX_W'(WI_RESERVED)) |-> (bus_rdata == '0));
    // R7
    mirror_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_set_we || priv_clr_we) |=> $stable(sh_en));
    // R10
    irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (summary == '0));
    // R4
    priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((summary[PRIV_W-1:0] & ~priv_en) == '0));
endmodule

// File: tb/bank_irq_ctrl_tb_top.sv
// Directed bench for the banked interrupt controller.
module bank_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] shared_irq_in = '0;
    logic [7:0]  priv_irq_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    bank_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shared_irq_in(shared_irq_in), .priv_irq_in(priv_irq_in),
        .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_write2(input logic [7:0] a1, input logic [31:0] d1,
                              input logic [7:0] a2, input logic [31:0] d2);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a1; bus_wdata = d1;
        @(negedge clk);
        bus_addr = a2; bus_wdata = d2;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        shared_irq_in = '1; priv_irq_in = '1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        read_chk("R1 en1", 8'h10, 32'h0);
        read_chk("R1 en2", 8'h14, 32'h0);
        read_chk("R1 enp", 8'h18, 32'h0);
        read_chk("R1 pend1", 8'h04, 32'h0);
        read_chk("R1 summary", 8'h00, 32'h0);
        check("R1 irq", {31'd0, irq_out}, 32'h0);
        shared_irq_in = '0; priv_irq_in = '0;
        settle();
    endtask

    task automatic t_set();
        bus_write(8'h10, 32'h0000_00F0);
        read_chk("R2 set1", 8'h10, 32'h0000_00F0);
        bus_write(8'h10, 32'h0000_000F);
        read_chk("R2 set1 keep", 8'h10, 32'h0000_00FF);
        bus_write(8'h14, 32'h8000_0001);
        read_chk("R8 clr2 addr readback", 8'h20, 32'h8000_0001);
        bus_write(8'h18, 32'h0000_0003);
        read_chk("R2 setp", 8'h18, 32'h0000_0003);
        read_chk("R8 clrp addr readback", 8'h24, 32'h0000_0003);
    endtask

    task automatic t_clear();
        bus_write(8'h1C, 32'h0000_0030);
        read_chk("R3 clr1", 8'h10, 32'h0000_00CF);
        bus_write(8'h20, 32'h0000_0001);
        read_chk("R3 clr2", 8'h14, 32'h8000_0000);
        bus_write(8'h24, 32'h0000_0001);
        read_chk("R3 clrp", 8'h18, 32'h0000_0002);
    endtask

    task automatic t_pending();
        shared_irq_in = 64'h8000_0001_0000_00FF;
        priv_irq_in = 8'h03;
        settle();
        read_chk("R4 pend1", 8'h04, 32'h0000_00CF);
        read_chk("R4 pend2", 8'h08, 32'h8000_0000);
        read_chk("R6 R7 summary", 8'h00, 32'h0000_0702);
        check("R10 irq high", {31'd0, irq_out}, 32'h1);
    endtask

    task automatic t_no_clear();
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        read_chk("R5 pend1 kept", 8'h04, 32'h0000_00CF);
        read_chk("R5 summary kept", 8'h00, 32'h0000_0702);
        shared_irq_in[31:0] = 32'h0000_00F7;
        settle();
        read_chk("R5 drop with source", 8'h04, 32'h0000_00C7);
        read_chk("R7 mirror drop", 8'h00, 32'h0000_0302);
    endtask

    task automatic t_mirror();
        bus_write(8'h18, 32'hFFFF_FC00);
        read_chk("R7 en1 untouched", 8'h10, 32'h0000_00CF);
        read_chk("R7 en2 untouched", 8'h14, 32'h8000_0000);
        read_chk("R7 enp untouched", 8'h18, 32'h0000_0002);
        bus_write(8'h10, 32'h0000_0200);
        shared_irq_in[31:0] = 32'h0000_02F7;
        settle();
        read_chk("R7 mirror line9", 8'h00, 32'h0000_0B02);
        bus_write(8'h24, 32'hFFFF_FF00);
        read_chk("R7 clrp keeps en1", 8'h10, 32'h0000_02CF);
        read_chk("R7 clrp keeps mirror", 8'h00, 32'h0000_0B02);
    endtask

    task automatic t_undefined();
        read_chk("R9 rsvd 0C", 8'h0C, 32'h0);
        read_chk("R9 off 28", 8'h28, 32'h0);
        read_chk("R9 off FC", 8'hFC, 32'h0);
        read_chk("R9 misaligned", 8'h11, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        bus_write(8'h11, 32'hFFFF_FFFF);
        bus_write(8'h1D, 32'hFFFF_FFFF);
        read_chk("R9 writes ignored en1", 8'h10, 32'h0000_02CF);
        read_chk("R9 writes ignored en2", 8'h14, 32'h8000_0000);
        read_chk("R9 writes ignored enp", 8'h18, 32'h0000_0002);
    endtask

    task automatic t_irq_or();
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'h0000_00FF);
        check("R10 irq low all disabled", {31'd0, irq_out}, 32'h0);
        bus_write(8'h14, 32'h8000_0000);
        check("R10 irq from bank2", {31'd0, irq_out}, 32'h1);
        bus_write(8'h20, 32'h8000_0000);
        bus_write(8'h18, 32'h0000_0001);
        check("R10 irq from private", {31'd0, irq_out}, 32'h1);
    endtask

    task automatic t_latency();
        @(negedge clk);
        priv_irq_in = 8'h00;
        @(negedge clk);
        check("R11 still high after one edge", {31'd0, irq_out}, 32'h1);
        @(negedge clk);
        check("R11 low after two edges", {31'd0, irq_out}, 32'h0);
        priv_irq_in = 8'h01;
        @(negedge clk);
        check("R11 still low after one edge", {31'd0, irq_out}, 32'h0);
        @(negedge clk);
        check("R11 high after two edges", {31'd0, irq_out}, 32'h1);
    endtask

    task automatic t_last_wins();
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write2(8'h10, 32'h0000_0020, 8'h1C, 32'h0000_0020);
        read_chk("R12 set then clear", 8'h10, 32'h0000_0000);
        bus_write2(8'h1C, 32'h0000_0020, 8'h10, 32'h0000_0020);
        read_chk("R12 clear then set", 8'h10, 32'h0000_0020);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_set();
        t_clear();
        t_pending();
        t_no_clear();
        t_mirror();
        t_undefined();
        t_irq_or();
        t_latency();
        t_last_wins();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule